// File: doc/BRIEF.md
# Comma-Aligned Deserializer with Byte Sync

This block rebuilds 10-bit characters from a retimed serial bit stream. Each accepted bit, marked by a bit-valid strobe, enters a two-character history. One word leaves the block for every ten accepted bits, with a one-cycle word strobe. Two byte-clock phases run 180 degrees apart and mark which character of a two-character pair is on the output. An input selector picks either the line bit or an internal loopback bit, and a loss-of-signal input forces the output word to all ones.

While comma search is enabled, the block watches for the seven-bit opening of a positive-disparity comma. If that opening is found off the current character grid, the framing is moved so that the comma leaves the block as the leading character of a new pair. The comma's first bit is then on word bit 0. The output cadence is only ever lengthened during the move and is never shortened. A comma that already sits on the grid leaves the cadence untouched. In both cases a comma flag travels with the comma's word.

Top module: `comma_deser`

## Requirements
- R1: Once the internal reset has been released, and before any bit has been accepted, `word_stb` and `comma_det` are 0, `bclk_lead` is 0, `bclk_trail` is 1 and `rx_word` is 0x3FF.
- R2: Bits are accepted only in cycles where `bit_vld` is high. Bit k of a word is the k-th received bit of its character. A strobe raised on the n-th accepted bit carries accepted bits n-19 through n-10, and bits before the first one count as 1. On a stable grid, strobes are exactly 10 accepted bits apart.
- R3: A comma opening is the received sequence 0,0,1,1,1,1,1, which is word bits 0 and 1 equal to 0 and bits 2 to 6 equal to 1. Bits 7 to 9 are ignored.
- R4: While `comma_en` is low, no comma is flagged and the framing is kept, even for an off-grid comma.
- R5: An off-grid comma is output with its first bit on word bit 0. The strobe interval that contains the move is stretched to p+10 accepted bits, where p is the number of bits accepted since the last strobe, and it never falls below 10.
- R6: After a move, the comma word is the leading character of a pair, so `bclk_lead` rises with it.
- R7: A comma already on the grid does not change the strobe interval or the slot it occupies.
- R8: `comma_det` is high for exactly the one strobe that carries the comma word.
- R9: While `los` is high, `rx_word` reads 0x3FF. Once it is released, the normal words return.
- R10: With `wrap_en` high, `loop_bit` is deserialized and `line_bit` is ignored. With `wrap_en` low, the roles are reversed.
- R11: At each strobe, `bclk_lead` is high for the leading character of a pair and low for the trailing one, and `bclk_trail` is its complement. Both change only together with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Qualifies the selected serial bit this cycle |
| line_bit | input | 1 | Serial bit from the line |
| loop_bit | input | 1 | Serial bit from the internal loopback path |
| wrap_en | input | 1 | Selects loop_bit instead of line_bit |
| comma_en | input | 1 | Enables comma search and realignment |
| los | input | 1 | Loss of signal; forces rx_word to all ones |
| rx_word | output | 10 | Recovered character, bit 0 received first |
| word_stb | output | 1 | One-cycle pulse when a new word is presented |
| comma_det | output | 1 | Marks the word that holds a comma |
| bclk_lead | output | 1 | Byte-clock phase, high for the leading character of a pair |
| bclk_trail | output | 1 | Byte-clock phase, complement of bclk_lead |

## Verification
An on-grid comma in the trailing slot completes on the same accepted bit that emits the previous character. Detection and word emission therefore fall in one cycle. The bench provokes this by sending a comma directly after a character boundary in the trailing position. It then judges the outcome on the comma flag: the flag must be attached to the comma's own word, emitted ten bits later, and never to the character emitted in the detection cycle. The strobe interval is also checked to confirm it stays at ten bits.

// File: rtl/cd_pkg.sv
package cd_pkg;
  // Default framing: ten-bit characters, seven-bit comma opening.
  // Bit k of the comma sequence is the k-th received bit.
  localparam int unsigned CD_CHAR_W  = 10;
  localparam int unsigned CD_COMMA_W = 7;
  localparam logic [CD_COMMA_W-1:0] CD_COMMA_SEQ = 7'b1111100;
endpackage

// File: rtl/cd_in_sel.sv
module cd_in_sel (
  input  logic wrap_en,
  input  logic line_bit,
  input  logic loop_bit,
  output logic sel_bit
);
  always_comb begin
    sel_bit = line_bit;
    if (wrap_en) sel_bit = loop_bit;
  end
endmodule

// File: rtl/cd_history.sv
module cd_history #(
  parameter int unsigned CHAR_W  = cd_pkg::CD_CHAR_W,
  parameter int unsigned COMMA_W = cd_pkg::CD_COMMA_W,
  parameter logic [COMMA_W-1:0] COMMA_SEQ = cd_pkg::CD_COMMA_SEQ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic              comma_en,
  output logic [CHAR_W-1:0] old_nxt,
  output logic              hit
);
  localparam int unsigned HIST_W = 2 * CHAR_W;

  logic [HIST_W-1:0]  hist_q;
  logic [HIST_W-1:0]  hist_d;
  logic [COMMA_W-1:0] eq_v;

  // Newest bit enters at the top; bit 0 is the oldest.
  always_comb begin
    hist_d = hist_q;
    if (bit_vld) hist_d = {bit_in, hist_q[HIST_W-1:1]};
  end

  // Compare the newer character slot against the comma opening, bit by bit.
  for (genvar k = 0; k < COMMA_W; k++) begin : g_match
    assign eq_v[k] = ~(hist_d[CHAR_W+k] ^ COMMA_SEQ[k]);
  end

  assign hit     = bit_vld & comma_en & (&eq_v);
  assign old_nxt = hist_d[CHAR_W-1:0];

  // Ones at reset: a fresh stream cannot fake a comma out of cleared history.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '1;
    else if (bit_vld) hist_q <= hist_d;
  end
endmodule

// File: rtl/cd_frame.sv
module cd_frame #(
  parameter int unsigned CHAR_W = cd_pkg::CD_CHAR_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic hit,
  output logic emit,
  output logic lead,
  output logic comma_due
);
  localparam int unsigned PAIR_W = 2 * CHAR_W;
  localparam int unsigned POS_W  = $clog2(PAIR_W);
  localparam int unsigned GAP_W  = $clog2(PAIR_W + 1);
  localparam logic [POS_W-1:0] LEAD_END  = POS_W'(CHAR_W - 1);
  localparam logic [POS_W-1:0] TRAIL_END = POS_W'(PAIR_W - 1);

  logic [POS_W-1:0] pos_q, pos_d, pos_inc;
  logic             pend_q, pend_d;
  logic             slot_end, realign;
  logic [GAP_W-1:0] gap_q, gap_d;

  always_comb begin
    pos_inc  = (pos_q == TRAIL_END) ? '0 : pos_q + 1'b1;
    slot_end = (pos_inc == LEAD_END) || (pos_inc == TRAIL_END);
    realign  = bit_vld & hit & ~slot_end;
    emit     = bit_vld & slot_end;
    lead     = (pos_inc == LEAD_END);
    pos_d    = pos_q;
    if (bit_vld) pos_d = realign ? TRAIL_END : pos_inc;
    pend_d = pend_q;
    if (bit_vld & hit) pend_d = 1'b1;
    else if (emit)     pend_d = 1'b0;
    gap_d = gap_q;
    if (emit)                                    gap_d = '0;
    else if (bit_vld && gap_q < GAP_W'(PAIR_W))  gap_d = gap_q + 1'b1;
  end

  assign comma_due = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= TRAIL_END;
      pend_q <= 1'b0;
      gap_q  <= GAP_W'(PAIR_W);
    end else begin
      pos_q  <= pos_d;
      pend_q <= pend_d;
      gap_q  <= gap_d;
    end
  end

  // R5: two strobes are never closer than one character of accepted bits.
  p_no_sliver_r5: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (gap_q >= GAP_W'(CHAR_W - 1)));
endmodule

// File: rtl/comma_deser.sv
module comma_deser #(
  parameter int unsigned CHAR_W  = cd_pkg::CD_CHAR_W,
  parameter int unsigned COMMA_W = cd_pkg::CD_COMMA_W,
  parameter logic [COMMA_W-1:0] COMMA_SEQ = cd_pkg::CD_COMMA_SEQ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              line_bit,
  input  logic              loop_bit,
  input  logic              wrap_en,
  input  logic              comma_en,
  input  logic              los,
  output logic [CHAR_W-1:0] rx_word,
  output logic              word_stb,
  output logic              comma_det,
  output logic              bclk_lead,
  output logic              bclk_trail
);
  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic              sel_bit, hit, emit, lead, comma_due;
  logic [CHAR_W-1:0] old_nxt;
  logic [CHAR_W-1:0] word_q, word_d;
  logic              stb_q, stb_d, det_q, det_d, bl_q, bl_d, bt_q, bt_d;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  cd_in_sel u_sel (
    .wrap_en (wrap_en),
    .line_bit(line_bit),
    .loop_bit(loop_bit),
    .sel_bit (sel_bit)
  );

  cd_history #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_SEQ(COMMA_SEQ)) u_hist (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .bit_vld (bit_vld),
    .bit_in  (sel_bit),
    .comma_en(comma_en),
    .old_nxt (old_nxt),
    .hit     (hit)
  );

  cd_frame #(.CHAR_W(CHAR_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .bit_vld  (bit_vld),
    .hit      (hit),
    .emit     (emit),
    .lead     (lead),
    .comma_due(comma_due)
  );

  always_comb begin
    word_d = word_q;
    bl_d   = bl_q;
    bt_d   = bt_q;
    stb_d  = emit;
    det_d  = emit & comma_due;
    if (emit) begin
      word_d = old_nxt;
      bl_d   = lead;
      bt_d   = ~lead;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      word_q <= '1;
      stb_q  <= 1'b0;
      det_q  <= 1'b0;
      bl_q   <= 1'b0;
      bt_q   <= 1'b1;
    end else begin
      word_q <= word_d;
      stb_q  <= stb_d;
      det_q  <= det_d;
      bl_q   <= bl_d;
      bt_q   <= bt_d;
    end
  end

  assign rx_word    = los ? '1 : word_q;
  assign word_stb   = stb_q;
  assign comma_det  = det_q;
  assign bclk_lead  = bl_q;
  assign bclk_trail = bt_q;

  // R8: the comma flag only ever rides on a word strobe.
  p_det_with_stb_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    comma_det |-> word_stb);
  // R3: a flagged word really opens with the comma sequence.
  p_det_pattern_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    comma_det |-> (word_q[COMMA_W-1:0] == COMMA_SEQ));
  // R11: byte-clock phases hold between strobes (stretch, never sliver).
  p_clk_still_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !word_stb |-> ($stable(bclk_lead) && $stable(bclk_trail)));
  // R2: a strobe follows an accepted bit.
  p_stb_needs_bit_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    word_stb |-> $past(bit_vld));
endmodule

// File: tb/tb_comma_deser.sv
module tb_comma_deser;
  localparam logic [9:0] KCH = 10'h17C;

  logic       clk = 1'b0;
  logic       rst_n, bit_vld, line_bit, loop_bit, wrap_en, comma_en, los;
  logic [9:0] rx_word;
  logic       word_stb, comma_det, bclk_lead, bclk_trail;

  int tests = 0;
  int fails = 0;
  int nb = 0;
  int ns = 0;
  logic       sent [0:1023];
  logic [9:0] w_a  [0:127];
  logic       d_a  [0:127];
  logic       a_a  [0:127];
  logic       b_a  [0:127];
  logic       l_a  [0:127];
  int         s_a  [0:127];

  always #2 clk = ~clk;

  comma_deser dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .line_bit(line_bit),
    .loop_bit(loop_bit), .wrap_en(wrap_en), .comma_en(comma_en), .los(los),
    .rx_word(rx_word), .word_stb(word_stb), .comma_det(comma_det),
    .bclk_lead(bclk_lead), .bclk_trail(bclk_trail)
  );

  always @(negedge clk) begin
    if (rst_n && word_stb && ns < 128) begin
      w_a[ns] = rx_word; d_a[ns] = comma_det; a_a[ns] = bclk_lead;
      b_a[ns] = bclk_trail; l_a[ns] = los; s_a[ns] = nb;
      ns++;
    end
  end

  function automatic logic [9:0] model(int n);
    logic [9:0] w;
    for (int k = 0; k < 10; k++) begin
      int idx;
      idx  = n - 19 + k;
      w[k] = (idx >= 1) ? sent[idx] : 1'b1;
    end
    return w;
  endfunction

  function automatic int idx_at(int stamp);
    for (int i = 0; i < ns; i++) if (s_a[i] == stamp) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_vld = 0; line_bit = 0; loop_bit = 0;
    wrap_en = 0; comma_en = 1; los = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 nb = 0; ns = 0;
  endtask

  task automatic send_bit(logic b, int idle);
    for (int i = 0; i < idle; i++) begin
      bit_vld = 0; line_bit = ~b; loop_bit = ~b;
      @(posedge clk); #1;
    end
    bit_vld = 1;
    if (wrap_en) begin loop_bit = b; line_bit = ~b; end
    else begin line_bit = b; loop_bit = ~b; end
    @(posedge clk); #1;
    nb++; sent[nb] = b;
  endtask

  task automatic send_char(logic [9:0] c, int idle);
    for (int k = 0; k < 10; k++) send_bit(c[k], idle);
  endtask

  task automatic prefix(int idle);
    send_bit(1, idle); send_bit(0, idle); send_bit(1, idle);
    send_char(KCH, idle);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) send_char(10'h155, 0);
    bit_vld = 0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic words_ok(string req);
    for (int i = 0; i < ns; i++) begin
      logic [9:0] e;
      e = l_a[i] ? 10'h3FF : model(s_a[i]);
      chk(w_a[i] == e, req, "word", w_a[i], e);
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(word_stb == 0 && comma_det == 0, "R1", "strobe/flag", {word_stb, comma_det}, 0);
    chk(bclk_lead == 0 && bclk_trail == 1, "R1", "phases", {bclk_lead, bclk_trail}, 1);
    chk(rx_word == 10'h3FF, "R1", "word", rx_word, 10'h3FF);
    @(posedge clk); #1;
  endtask

  task automatic t_realign();
    int i;
    do_reset();
    prefix(0);
    send_char(10'h155, 0); send_char(10'h2AA, 0); send_char(10'h333, 0);
    send_char(10'h0F0, 0); send_char(10'h1C7, 0);
    drain();
    i = idx_at(23);
    chk(i == 1, "R5", "comma strobe index", i, 1);
    if (i == 1) begin
      chk(s_a[1] - s_a[0] == 13, "R5", "stretched gap", s_a[1] - s_a[0], 13);
      chk(w_a[1] == KCH, "R5", "comma on bit 0", w_a[1], KCH);
      chk(d_a[1] == 1, "R8", "flag on comma", d_a[1], 1);
      chk(a_a[1] == 1, "R6", "lead phase rises with comma", a_a[1], 1);
      for (int j = 2; j < 7; j++) begin
        chk(s_a[j] - s_a[j-1] == 10, "R2", "gap", s_a[j] - s_a[j-1], 10);
        chk(d_a[j] == 0, "R8", "single flag", d_a[j], 0);
        chk(a_a[j] == logic'(j % 2), "R11", "phase order", a_a[j], j % 2);
        chk(b_a[j] == ~a_a[j], "R11", "complement", b_a[j], ~a_a[j]);
      end
    end
    words_ok("R2");
  endtask

  task automatic t_aligned();
    do_reset();
    prefix(0);
    send_char(10'h155, 0); send_char(10'h2AA, 0); send_char(KCH, 0);
    send_char(10'h333, 0); send_char(10'h0F0, 0); send_char(KCH, 0);
    drain();
    for (int j = 2; j < 9; j++)
      chk(s_a[j] - s_a[j-1] == 10, "R7", "gap kept", s_a[j] - s_a[j-1], 10);
    chk(d_a[3] == 0, "R8", "flag not on prior word", d_a[3], 0);
    chk(d_a[4] == 1 && w_a[4] == KCH, "R7", "trail comma flagged", {d_a[4], w_a[4]}, {1'b1, KCH});
    chk(a_a[4] == 0, "R7", "trail slot kept", a_a[4], 0);
    chk(d_a[7] == 1 && a_a[7] == 1, "R7", "lead comma flagged", {d_a[7], a_a[7]}, 3);
    chk(d_a[5] == 0 && d_a[6] == 0 && d_a[8] == 0, "R8", "no stray flag", 0, 0);
    words_ok("R7");
  endtask

  task automatic t_disabled();
    int bad;
    do_reset();
    prefix(0);
    comma_en = 0;
    send_bit(1, 0); send_bit(0, 0); send_bit(1, 0);
    send_char(KCH, 0); send_char(10'h333, 0); send_char(10'h1C7, 0);
    drain();
    bad = 0;
    for (int j = 2; j < ns; j++) begin
      if (s_a[j] - s_a[j-1] != 10) bad++;
      if (d_a[j] != 0) bad++;
    end
    chk(bad == 0, "R4", "grid and flag held with search off", bad, 0);
    chk(ns >= 7, "R4", "strobe count", ns, 7);
    words_ok("R4");
  endtask

  task automatic t_los();
    int forced;
    do_reset();
    prefix(0);
    send_char(10'h155, 0);
    los = 1;
    send_char(10'h000, 0);
    chk(rx_word == 10'h3FF, "R9", "forced between strobes", rx_word, 10'h3FF);
    send_char(10'h333, 0);
    los = 0;
    send_char(10'h2AA, 0); send_char(10'h0F0, 0);
    drain();
    forced = 0;
    for (int j = 0; j < ns; j++) if (l_a[j]) forced++;
    chk(forced >= 2, "R9", "strobes seen under loss", forced, 2);
    words_ok("R9");
  endtask

  task automatic t_wrap();
    int i;
    do_reset();
    wrap_en = 1;
    prefix(0);
    send_char(10'h333, 0); send_char(10'h1C7, 0);
    drain();
    i = idx_at(23);
    chk(i == 1 && d_a[1] == 1 && w_a[1] == KCH, "R10", "loopback comma", i, 1);
    words_ok("R10");
    wrap_en = 0;
  endtask

  task automatic t_gaps();
    int i;
    do_reset();
    prefix(2);
    send_char(10'h2AA, 1); send_char(10'h0F0, 3);
    drain();
    i = idx_at(23);
    chk(i == 1 && d_a[1] == 1, "R2", "comma under idle bits", i, 1);
    chk(s_a[2] - s_a[1] == 10, "R2", "gap counts accepted bits", s_a[2] - s_a[1], 10);
    words_ok("R2");
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_realign();
    t_aligned();
    t_disabled();
    t_los();
    t_wrap();
    t_gaps();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule